// File: doc/BRIEF.md
# Reset Cause and Soft Reset Trigger Register

This block is a single 32-bit control and status word inside a host bridge's register space. It remembers what kind of reset brought the system up, and it lets software start a soft reset of either of two kinds: a soft power-on style reset or a soft externally initiated reset. A software write that starts either kind produces a one-cycle system reset request. The reset sequencer outside this block acts on that request and answers with a reset event, which comes back in on `rst_evt`.

The five upper bits of the word carry meaning and the 27 low bits always read as zero. Three of the five are status flags that software clears by writing 1 to them:

- the power-on flag (bit 31);
- button power-on (bit 28);
- button external (bit 27).

The other two are trigger bits that a write of 1 sets:

- soft power-on (bit 30);
- soft external (bit 29).

A small saturating counter tracks reset events. The first event after a cold start, or after a soft power-on trigger, loads the word with only the power-on flag set. Later events leave the word as it was.

Top module: `rstcsr_top`

## Requirements
- R1: While and after `rst_n` is low, the register reads as 0x00000000 and `sys_rst_req` is low.
- R2: A reset event (`rst_evt` high at a clock edge) while the event counter is zero loads the register with exactly 0x80000000 (only bit 31 set).
- R3: A reset event while the counter is non-zero leaves the register unchanged. The counter (CNT_W bits) saturates at its maximum and never wraps back to zero, so any number of further events keeps the contents.
- R4: An accepted write clears bits 31, 28 and 27 wherever the write data has a 1 in that position, and leaves them alone where it has a 0.
- R5: An accepted write sets bits 30 and 29 wherever the write data has a 1 in that position. A 0 written there leaves the bit unchanged.
- R6: Bits 26:0 always read as zero, whatever data is written.
- R7: An accepted write with data bit 30 set raises `sys_rst_req` in the cycle after the write edge. It also clears the event counter, so the next reset event loads 0x80000000.
- R8: An accepted write with data bit 29 set and bit 30 clear raises `sys_rst_req` in the cycle after the write edge and leaves the counter untouched. An accepted write with both bits clear raises no request.
- R9: Only the word whose address has bits 15:3 equal to BASE_ADDR bits 15:3 and bit 2 set is read and written. The companion word (bit 2 clear) reads as 0 and ignores writes. Every other address reads 0 and ignores writes.
- R10: A write in the same cycle as a reset event is discarded entirely: it changes no register bit and raises no request.
- R11: `sys_rst_req` is high for exactly one cycle per accepted triggering write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset: clears the register and the counter |
| cfg_wr | input | 1 | Write strobe for the register interface |
| cfg_addr | input | 16 | Byte address within the bridge register space |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| rst_evt | input | 1 | Reset event reported by the system reset sequencer |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A software write and a reset event can land on the same clock edge. The bench provokes this directly by holding `cfg_wr` and an injected `rst_evt` high together, once with clear-type data and once with soft power-on data. A correct block leaves the register word as it was and raises no request.

The same collision also comes up in normal use. With the request looped back as the event input, the loop-back event arrives one cycle after a triggering write, so a write issued back-to-back with it would collide. The bench therefore checks the register contents right after each loop-back event, against the counter state that the requirements predict.

// File: rtl/rstcsr_pkg.sv
package rstcsr_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned FLAG_LO = 27;            // lowest meaningful bit
  localparam int unsigned FLAG_N  = DATA_W - FLAG_LO;

  localparam int unsigned B_PWRON  = 31;
  localparam int unsigned B_SWPOR  = 30;
  localparam int unsigned B_SWEXT  = 29;
  localparam int unsigned B_BTNPOR = 28;
  localparam int unsigned B_BTNEXT = 27;

  localparam logic [DATA_W-1:0] LIVE_MASK = 32'hF800_0000;
  localparam logic [DATA_W-1:0] W1C_MASK  = (32'd1 << B_PWRON) | (32'd1 << B_BTNPOR) | (32'd1 << B_BTNEXT);
  localparam logic [DATA_W-1:0] W1S_MASK  = (32'd1 << B_SWPOR) | (32'd1 << B_SWEXT);
  localparam logic [DATA_W-1:0] COLD_VAL  = (32'd1 << B_PWRON);
endpackage

// File: rtl/rstcsr_decode.sv
module rstcsr_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              evt,
  output logic              sel,
  output logic              wr_acc
);
  logic hit;

  assign hit    = (addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
  assign sel    = hit && addr[2];
  // a reset event in the same cycle discards the write
  assign wr_acc = wr && sel && !evt;
endmodule

// File: rtl/rstcsr_cnt.sv
module rstcsr_cnt #(
  parameter int unsigned CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  output logic zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clr)                       cnt_q <= '0;
    else if (inc && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
  end

  assign zero = (cnt_q == '0);

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc && !clr) |=> (cnt_q == CNT_MAX));

  a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> zero);
endmodule

// File: rtl/rstcsr_reg.sv
module rstcsr_reg
  import rstcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt,
  input  logic              first,
  output logic [DATA_W-1:0] q,
  output logic              req,
  output logic              cnt_clr
);
  logic [DATA_W-1:0] wm;
  logic [FLAG_N-1:0] flags_q, flags_d;
  logic              req_d;

  assign wm = wdata & LIVE_MASK;

  always_comb begin
    flags_d = flags_q;
    req_d   = 1'b0;
    if (evt) begin
      if (first) flags_d = COLD_VAL[DATA_W-1:FLAG_LO];
    end else if (wr_acc) begin
      flags_d = (flags_q & ~(wm[DATA_W-1:FLAG_LO] & W1C_MASK[DATA_W-1:FLAG_LO]))
              | (wm[DATA_W-1:FLAG_LO] & W1S_MASK[DATA_W-1:FLAG_LO]);
      req_d   = wm[B_SWPOR] || wm[B_SWEXT];
    end
  end

  assign cnt_clr = wr_acc && wm[B_SWPOR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      req     <= 1'b0;
    end else begin
      flags_q <= flags_d;
      req     <= req_d;
    end
  end

  assign q = {flags_q, {FLAG_LO{1'b0}}};

  a_r7_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(wr_acc && (wdata[B_SWPOR] || wdata[B_SWEXT])));

  a_r2_cold_load: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && first) |=> (q == COLD_VAL));

  a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !first) |=> $stable(q));

  a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    q[FLAG_LO-1:0] == '0);
endmodule

// File: rtl/rstcsr_top.sv
module rstcsr_top
  import rstcsr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'hF020,
  parameter int unsigned CNT_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              rst_evt,
  output logic              sys_rst_req
);
  logic              sel, wr_acc, first, cnt_clr;
  logic [DATA_W-1:0] reg_q;

  rstcsr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(cfg_addr), .wr(cfg_wr), .evt(rst_evt), .sel(sel), .wr_acc(wr_acc)
  );

  rstcsr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(rst_evt), .clr(cnt_clr), .zero(first)
  );

  rstcsr_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wdata(cfg_wdata),
    .evt(rst_evt), .first(first), .q(reg_q), .req(sys_rst_req), .cnt_clr(cnt_clr)
  );

  assign cfg_rdata = sel ? reg_q : '0;

  a_r10_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && cfg_wr) |=> !sys_rst_req);

  a_r9_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !sel && !rst_evt) |=> $stable(reg_q));
endmodule

// File: tb/rstcsr_top_tb.sv
module rstcsr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_addr = 16'hF024;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sys_rst_req;
  logic        loop_en = 1'b0;
  logic        inj = 1'b0;
  logic        rst_evt;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign rst_evt = (loop_en && sys_rst_req) || inj;

  rstcsr_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rst_evt(rst_evt),
    .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cold();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic event_pulse();
    @(negedge clk); inj = 1'b1;
    @(negedge clk); inj = 1'b0;
  endtask

  // after return: one edge past the write, address still 0xF024
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0; cfg_addr = 16'hF024;
    #1;
  endtask

  function automatic logic [4:0] model(input logic [4:0] s, input logic [4:0] w);
    return (s & ~(w & 5'b10011)) | (w & 5'b01100);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: cold reset state
    @(negedge clk); #1;
    chk("R1 rdata in reset", cfg_rdata, 32'h0);
    chk("R1 req in reset", {31'd0, sys_rst_req}, 32'd0);
    cold(); #1;
    chk("R1 rdata after reset", cfg_rdata, 32'h0);

    // R2: first event loads power-on flag
    event_pulse(); #1;
    chk("R2 first event", cfg_rdata, 32'h8000_0000);

    // R7: soft power-on trigger with loop-back
    loop_en = 1'b1;
    wr(16'hF024, 32'h4000_0000);
    chk("R7 req after write", {31'd0, sys_rst_req}, 32'd1);
    chk("R5 soft por bit set", cfg_rdata, 32'hC000_0000);
    @(negedge clk); #1;
    chk("R11 req one cycle", {31'd0, sys_rst_req}, 32'd0);
    chk("R7 reload after soft por", cfg_rdata, 32'h8000_0000);

    // R8: soft external trigger keeps contents
    wr(16'hF024, 32'h2000_0000);
    chk("R8 req after write", {31'd0, sys_rst_req}, 32'd1);
    @(negedge clk); #1;
    chk("R11 req drops", {31'd0, sys_rst_req}, 32'd0);
    chk("R8 contents kept", cfg_rdata, 32'hA000_0000);

    // R3: saturating counter, no wrap
    for (int i = 0; i < 5; i++) begin
      event_pulse(); #1;
      chk("R3 later event keeps", cfg_rdata, 32'hA000_0000);
    end

    // R9: companion word and foreign addresses
    wr(16'hF020, 32'hFFFF_FFFF);
    chk("R9 companion write ignored", cfg_rdata, 32'hA000_0000);
    chk("R9 no req companion", {31'd0, sys_rst_req}, 32'd0);
    cfg_addr = 16'hF020; #1;
    chk("R9 companion reads zero", cfg_rdata, 32'h0);
    wr(16'hF02C, 32'hFFFF_FFFF);
    chk("R9 outside write ignored", cfg_rdata, 32'hA000_0000);
    wr(16'hE024, 32'hFFFF_FFFF);
    chk("R9 alias write ignored", cfg_rdata, 32'hA000_0000);
    cfg_addr = 16'hE024; #1;
    chk("R9 alias reads zero", cfg_rdata, 32'h0);
    cfg_addr = 16'hF024;

    // R10: write colliding with event
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 32'hF800_0000; inj = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; inj = 1'b0; #1;
    chk("R10 collide contents", cfg_rdata, 32'hA000_0000);
    chk("R10 collide no req", {31'd0, sys_rst_req}, 32'd0);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 32'h4000_0000; inj = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; inj = 1'b0; #1;
    chk("R10 collide soft por no req", {31'd0, sys_rst_req}, 32'd0);
    event_pulse(); #1;
    chk("R10 counter not cleared", cfg_rdata, 32'hA000_0000);
    loop_en = 1'b0;

    // R4 R5 R6: sweep of two-write sequences over the live bits
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        logic [4:0] s;
        cold();
        event_pulse();
        s = 5'b10000;
        wr(16'hF024, {a[4:0], 27'h5A5_A5A5 ^ 27'(b)});
        s = model(s, a[4:0]);
        chk("R4 R5 R6 first write", cfg_rdata, {s, 27'd0});
        chk("R7 R8 req first", {31'd0, sys_rst_req}, {31'd0, a[3] | a[2]});
        wr(16'hF024, {b[4:0], 27'h7FF_FFFF});
        s = model(s, b[4:0]);
        chk("R4 R5 R6 second write", cfg_rdata, {s, 27'd0});
        chk("R7 R8 req second", {31'd0, sys_rst_req}, {31'd0, b[3] | b[2]});
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule